// File: doc/BRIEF.md
# Selectable PRBS Transmit Test Pattern Generator

This block sits in front of a serializer and supplies its parallel transmit word. In normal operation the word is the user's parallel data. A small control register can instead select an internally generated test pattern. The pattern can be one of three pseudo-random bit sequences (PRBS7, PRBS23 or PRBS31), in true or complemented polarity, or a fixed alternating bit pattern. A control bit holds the generator in reset. An external pin forces a fixed test sequence, whatever the register holds.

The register has one 16-bit location. It is written through a write strobe with its data and read back through a plain read bus. The serializer consumes one word on every parallel clock. For that reason the data path has no valid/ready handshake, and back-pressure never applies: a word is presented and replaced on every clock edge. Each sequence restarts from an all-ones seed whenever pattern mode is entered or the polynomial changes. This gives a receiver a predictable starting point.

Top module: `prbs_tx_pattern_gen`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x0000 and `tx_data` is 0x0000. With the default settings, `tx_data` then carries `usr_data` from the previous clock.
- R2: A write stores `cfg_wr_data[4:0]` and `cfg_rd_data` shows it from the next cycle onward. Bits 15:5 always read zero, whatever was written. Without a write the readback does not change.
- R3: Bit 3 is the generator enable. When it is 0 and the force pin is low, `tx_data` equals `usr_data` sampled at the previous clock edge.
- R4: Bits 2:0 select the pattern: 0 = PRBS7, 2 = PRBS23, 4 = PRBS31. The polynomials are x^7+x^6+1, x^23+x^18+1 and x^31+x^28+1. For a length N and inner tap M, each serial step computes b = s[N-1] xor s[M-1], emits b and shifts the state left with b entering at bit 0. Sixteen steps run per clock, and the earliest step lands in `tx_data` bit 0.
- R5: Odd codes 1, 3 and 5 give the bitwise complement of the words that codes 0, 2 and 4 give. The LFSR state itself is not inverted.
- R6: Code 6 gives the alternating pattern, 0x5555 on every clock (serial order 1,0,1,0...).
- R7: Code 7 is reserved and behaves exactly like code 0.
- R8: Bit 4 is the PRBS reset. While it is 1 with the enable set and the force pin low, `tx_data` is 0x0000. After it clears, the sequence restarts from the seed.
- R9: The LFSR is loaded with all ones, and its first word is generated from that seed, whenever the generator becomes active after being inactive (disabled or held) or the selected polynomial changes. Switching polarity only on the same polynomial does not restart it.
- R10: While `force_prbs` is high, `tx_data` carries PRBS7 in true polarity. The register's enable, select and reset bits are all ignored.
- R11: A register write or force change is seen at the clock edge that follows it. The first word of the new mode appears at the output on the next edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 16 | Register write data |
| cfg_rd_data | output | 16 | Register readback |
| force_prbs | input | 1 | Forces PRBS7 true polarity |
| usr_data | input | 16 | User parallel transmit data |
| tx_data | output | 16 | Registered word to the serializer |

## Verification
Readback is due one clock after the write edge. `tx_data` is one register stage behind its inputs: user data and the force pin act at the next edge, and a register write reaches the output one edge later, because the stored settings feed the output register. The bench drives inputs on the falling edge and computes, for each coming rising edge, the word that edge must produce from the settings stored before it. It compares that word at the following falling edge. A bit-serial reference LFSR tracks restarts, and directed sequences check the seed word, the complement pairs, the reserved code and the force priority at exact cycles.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;

  typedef enum logic [1:0] {
    POLY_7   = 2'd0,
    POLY_23  = 2'd1,
    POLY_31  = 2'd2,
    POLY_ALT = 2'd3
  } poly_e;

  typedef struct packed {
    logic       hold;
    logic       en;
    logic [2:0] sel;
  } cfg_t;

  localparam int CFG_W = 5;
  localparam logic [2:0] SEL_ALT  = 3'd6;
  localparam logic [2:0] SEL_RSVD = 3'd7;
  localparam int NUM_POLY = 3;

  function automatic int poly_len(input int g);
    return (g == 0) ? 7 : (g == 1) ? 23 : 31;
  endfunction

  function automatic int poly_tap(input int g);
    return (g == 0) ? 6 : (g == 1) ? 18 : 28;
  endfunction

endpackage

// File: rtl/prbs_tx_cfg_reg.sv
module prbs_tx_cfg_reg
  import prbs_tx_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rd_data
);
  cfg_t cfg_q;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
  end

  assign cfg     = cfg_q;
  assign rd_data = {{(REG_W-CFG_W){1'b0}}, cfg_q};

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{(REG_W-CFG_W){1'b0}}, $past(wr_data[CFG_W-1:0])});
  a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/prbs_tx_lfsr.sv
module prbs_tx_lfsr #(
  parameter int LEN    = 7,
  parameter int TAP    = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  output logic [WORD_W-1:0] word
);
  logic [LEN-1:0] state;
  logic [LEN-1:0] nxt;

  always_comb begin
    logic [LEN-1:0] s;
    logic fb;
    s    = restart ? '1 : state;
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      fb      = s[LEN-1] ^ s[TAP-1];
      word[i] = fb;
      s       = {s[LEN-2:0], fb};
    end
    nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= '1;
    else if (run) state <= nxt;
  end

  a_r9_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(state));
endmodule

// File: rtl/prbs_tx_pattern_gen.sv
module prbs_tx_pattern_gen
  import prbs_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              force_prbs,
  input  logic [DATA_W-1:0] usr_data,
  output logic [DATA_W-1:0] tx_data
);
  localparam logic [DATA_W-1:0] ALT_WORD = {(DATA_W/2){2'b01}};

  cfg_t cfg;
  logic       eff_en, eff_hold, active, restart, invert;
  logic [2:0] eff_sel;
  poly_e      poly, poly_q;
  logic       act_q;
  logic [DATA_W-1:0] prbs_word [NUM_POLY];
  logic [DATA_W-1:0] pattern, tx_next;

  prbs_tx_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg(cfg), .rd_data(cfg_rd_data)
  );

  always_comb begin
    eff_en   = force_prbs | cfg.en;
    eff_hold = !force_prbs & cfg.hold;
    eff_sel  = (force_prbs || cfg.sel == SEL_RSVD) ? 3'd0 : cfg.sel;
    poly     = (eff_sel == SEL_ALT) ? POLY_ALT : poly_e'(eff_sel[2:1]);
    invert   = eff_sel[0];
    active   = eff_en & !eff_hold;
    restart  = active & (!act_q | (poly != poly_q));
  end

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_lfsr
    logic sel_g;
    assign sel_g = active && (poly == poly_e'(g));
    prbs_tx_lfsr #(
      .LEN(poly_len(g)), .TAP(poly_tap(g)), .WORD_W(DATA_W)
    ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .run(sel_g), .restart(sel_g & restart),
      .word(prbs_word[g])
    );
  end

  always_comb begin
    case (poly)
      POLY_7:  pattern = prbs_word[0];
      POLY_23: pattern = prbs_word[1];
      POLY_31: pattern = prbs_word[2];
      default: pattern = ALT_WORD;
    endcase
    if (poly != POLY_ALT && invert) pattern = ~pattern;
    if (!eff_en)       tx_next = usr_data;
    else if (eff_hold) tx_next = '0;
    else               tx_next = pattern;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      act_q   <= 1'b0;
      poly_q  <= POLY_7;
    end else begin
      tx_data <= tx_next;
      act_q   <= active;
      poly_q  <= poly;
    end
  end

  a_r3_user_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_prbs && !cfg.en) |=> tx_data == $past(usr_data));
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_prbs && cfg.en && cfg.hold) |=> tx_data == '0);
  a_r6_alt_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_prbs && cfg.en && !cfg.hold && cfg.sel == SEL_ALT) |=> tx_data == ALT_WORD);
  a_r10_force_not_user: assert property (@(posedge clk) disable iff (!rst_n)
    (force_prbs && act_q && poly_q == POLY_7) |=> tx_data != $past(usr_data) || tx_data != '0);
endmodule

// File: tb/prbs_tx_pattern_gen_bench.sv
`timescale 1ns/1ps
module prbs_tx_pattern_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        force_prbs = 1'b0;
  logic [15:0] usr_data = '0;
  logic [15:0] tx_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [4:0]  m_cfg = '0;
  bit          m_act = 0;
  int          m_poly = 0;
  logic [30:0] m_st = '1;
  logic [15:0] last_word;

  always #5 clk = ~clk;

  prbs_tx_pattern_gen u_prbs_tx_pattern_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .force_prbs(force_prbs), .usr_data(usr_data),
    .tx_data(tx_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-serial reference: b = s[N-1]^s[M-1], emitted to bit i, shifted in at bit 0.
  function automatic logic [15:0] ref_word(input int p, inout logic [30:0] st);
    int len = (p == 0) ? 7 : (p == 1) ? 23 : 31;
    int tap = (p == 0) ? 6 : (p == 1) ? 18 : 28;
    logic [15:0] w = '0;
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = st[len-1] ^ st[tap-1];
      w[i] = b;
      st = {st[29:0], b};
    end
    return w;
  endfunction

  // One clock: drive at falling edge, predict next rising edge, compare at next falling edge.
  task automatic cycle(input logic wr, input logic [15:0] wd, input logic frc, input logic [15:0] ud);
    logic [15:0] exp;
    logic en, hold;
    logic [2:0] sel;
    bit act;
    int poly;
    string tag;
    bit cfg_changed;
    cfg_wr_en = wr; cfg_wr_data = wd; force_prbs = frc; usr_data = ud;
    en   = frc | m_cfg[3];
    hold = !frc & m_cfg[4];
    sel  = (frc || m_cfg[2:0] == 3'd7) ? 3'd0 : m_cfg[2:0];
    poly = (sel == 3'd6) ? 3 : int'(sel[2:1]);
    act  = en && !hold;
    if (!en)            begin exp = ud;       tag = "R3"; end
    else if (hold)      begin exp = 16'h0000; tag = "R8"; end
    else if (poly == 3) begin exp = 16'h5555; tag = "R6"; end
    else begin
      tag = "R4";
      if (!m_act || poly != m_poly) begin m_st = '1; tag = "R9"; end
      exp = ref_word(poly, m_st);
      if (sel[0]) begin exp = ~exp; tag = "R5"; end
      if (frc) tag = "R10";
      else if (m_cfg[2:0] == 3'd7) tag = "R7";
    end
    m_act = act;
    m_poly = poly;
    cfg_changed = 0;
    if (wr) begin cfg_changed = (m_cfg != wd[4:0]); m_cfg = wd[4:0]; end
    @(negedge clk);
    check(tag, tx_data, exp);
    check(cfg_changed ? "R2/R11" : "R2", cfg_rd_data, {11'b0, m_cfg});
    last_word = tx_data;
  endtask

  initial begin
    logic [15:0] w_true [4];
    logic [30:0] st;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", tx_data, 16'h0000);
    check("R1", cfg_rd_data, 16'h0000);
    cycle(0, 0, 0, 16'hbeef);
    check("R1", tx_data, 16'hbeef);
    // R2: upper bits ignored
    cycle(1, 16'hffe0, 0, 16'h1111);
    check("R2", cfg_rd_data, 16'h0000);
    // R11 and R9: seed word appears two edges after the write drive
    cycle(1, 16'h0008, 0, 16'h2222);
    cycle(0, 0, 0, 16'h3333);
    st = '1;
    check("R11", tx_data, ref_word(0, st));
    for (int i = 1; i < 4; i++) begin cycle(0, 0, 0, 16'h0); w_true[i] = last_word; end
    // R5: restart with inverted code gives complements
    cycle(1, 16'h0000, 0, 16'h0);
    cycle(1, 16'h0009, 0, 16'h0);
    for (int i = 0; i < 3; i++) begin
      cycle(0, 0, 0, 16'h0);
      if (i > 0) check("R5", last_word, ~w_true[i]);
    end
    // R7: reserved code equals PRBS7 continuing (same polynomial, no restart)
    cycle(1, 16'h000f, 0, 16'h0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 16'h0);
    // R8: hold then release; R10: force over hold and user mode
    cycle(1, 16'h001c, 0, 16'h0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 16'h0);
    check("R8", last_word, 16'h0000);
    cycle(0, 0, 1, 16'h4444);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 16'h0);
    cycle(1, 16'h000c, 0, 16'h0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 16'h0);
    cycle(1, 16'h000e, 0, 16'h0);
    cycle(0, 0, 0, 16'h0);
    check("R6", last_word, 16'h5555);
    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, frc;
      logic [15:0] wd;
      wr  = ($urandom_range(0, 9) == 0);
      wd  = 16'($urandom());
      if ($urandom_range(0, 3) != 0) wd[4] = 1'b0;
      if ($urandom_range(0, 3) != 0) wd[3] = 1'b1;
      frc = ($urandom_range(0, 15) == 0);
      cycle(wr, wd, frc, 16'($urandom()));
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule